// File: doc/BRIEF.md
# Keyed Byte-Substitution and MDS Mixing Stage

This block computes the 32-bit h-function used inside the round function of a 128-bit-key Feistel block cipher. A 32-bit word enters together with two 32-bit session key words. Each of the four input bytes passes through its own keyed substitution chain. A chain is three fixed 8-bit permutations in series, with a key byte mixed in by XOR between the stages. The four substituted bytes are then combined by a 4x4 maximum-distance-separable matrix over GF(2^8).

Each fixed permutation is built from small 4-bit lookup tables with nibble mixing, so no 256-entry table is stored. The stage is pipelined with registers after each permutation level and after the matrix. It accepts one word per clock. A valid flag travels with each word and comes out four clocks later. Both key words must stay constant while words are in flight.

Top module: `hfn_core`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `valid_out` is 0 and `word_out` is 0.
- R2: Each fixed permutation splits its input byte x into a = x[7:4] and b = x[3:0]. It forms a1 = a^b and b1 = a ^ rotr1(b) ^ {a[0],3'b000}, then looks up a2 = T0[a1] and b2 = T1[b1]. It mixes again in the same way and looks up T2 on the a-path and T3 on the b-path. The result is {T3 result, T2 result}. The two permutation variants, P0 and P1, differ only in their four 16-entry tables.
- R3: Byte j of `word_in` (byte 0 = bits 7:0) feeds substitution chain j. Chain j applies its first permutation, XORs byte j of `key_inner`, applies its second permutation, XORs byte j of `key_outer`, and applies its third permutation. The permutation variants per chain are: chain 0 P0,P0,P1; chain 1 P1,P0,P0; chain 2 P0,P1,P1; chain 3 P1,P1,P0.
- R4: With y_j the output of chain j and z_j byte j of the result: z0 = y0 ^ EF*y1 ^ 5B*y2 ^ 5B*y3; z1 = 5B*y0 ^ EF*y1 ^ EF*y2 ^ y3; z2 = EF*y0 ^ 5B*y1 ^ y2 ^ EF*y3; z3 = EF*y0 ^ y1 ^ EF*y2 ^ 5B*y3. An all-zero matrix input gives an all-zero result.
- R5: All matrix products are in GF(2^8) reduced by x^8+x^6+x^5+x^3+1 (0x169).
- R6: A word presented with `valid_in` high at a rising edge appears on `word_out`, with `valid_out` high, exactly 4 rising edges later, counting that edge. Words may arrive on every clock, and each one produces exactly one result, in order.
- R7: While `valid_out` is low, `word_out` keeps the last result (or its reset value).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | `word_in` carries a word to transform |
| word_in | input | 32 | Input word; byte j feeds chain j |
| key_inner | input | 32 | Session key word XORed after the first permutation level |
| key_outer | input | 32 | Session key word XORed after the second permutation level |
| valid_out | output | 1 | `word_out` carries a new result |
| word_out | output | 32 | Transformed word, held between results |

## Verification
A wrong table nibble, a wrong mixing rotate or a swapped key byte corrupts one substituted byte. The matrix then spreads that error across all four output bytes, so the fault is visible on `word_out` exactly four edges after the word that hits it. A wrong reduction constant shows up only for products that overflow bit 7, which random words reach within a few results. A wrong stage enable or valid shift shows up as a result arriving in the wrong cycle, a missing or extra result, or `word_out` changing while `valid_out` is low.

// File: rtl/hfn_pkg.sv
package hfn_pkg;

   // Nibble tables, entry i held at bits [4i+3:4i]
   localparam logic [63:0] P0_TA = 64'h4ACE95B023F6D718;
   localparam logic [63:0] P0_TB = 64'hD9076A4F53218BCE;
   localparam logic [63:0] P0_TC = 64'h17423F8C09D6E5AB;
   localparam logic [63:0] P0_TD = 64'hAC5803B9E6214F7D;
   localparam logic [63:0] P1_TA = 64'h5CA04913E67FDB82;
   localparam logic [63:0] P1_TB = 64'h809F5AD673C4B2E1;
   localparam logic [63:0] P1_TC = 64'hF3B28DE0A96157C4;
   localparam logic [63:0] P1_TD = 64'hA802F746ED3C159B;

   // Permutation variant per chain (3 bits each) and level (bit within group)
   localparam logic [11:0] CHAIN_MAP = 12'b011_110_001_100;

   function automatic logic [3:0] nib_look(input logic [63:0] tab, input logic [3:0] idx);
      return tab[{idx, 2'b00} +: 4];
   endfunction

   function automatic logic [3:0] nib_mix(input logic [3:0] a, input logic [3:0] b);
      return a ^ {b[0], b[3:1]} ^ {a[0], 3'b000};
   endfunction

   function automatic logic [7:0] gf_dbl(input logic [7:0] v, input logic [8:0] poly);
      return {v[6:0], 1'b0} ^ (v[7] ? poly[7:0] : 8'h00);
   endfunction

endpackage

// File: rtl/hfn_qperm.sv
module hfn_qperm
   import hfn_pkg::*;
#(
   parameter bit VARIANT = 1'b0
) (
   input  logic [7:0] x_in,
   output logic [7:0] y_out
);

   localparam logic [63:0] TA = VARIANT ? P1_TA : P0_TA;
   localparam logic [63:0] TB = VARIANT ? P1_TB : P0_TB;
   localparam logic [63:0] TC = VARIANT ? P1_TC : P0_TC;
   localparam logic [63:0] TD = VARIANT ? P1_TD : P0_TD;

   logic [3:0] hi0, lo0, hi1, lo1, hi2, lo2, hi3, lo3;

   always_comb begin
      hi0   = x_in[7:4];
      lo0   = x_in[3:0];
      hi1   = hi0 ^ lo0;
      lo1   = nib_mix(hi0, lo0);
      hi2   = nib_look(TA, hi1);
      lo2   = nib_look(TB, lo1);
      hi3   = hi2 ^ lo2;
      lo3   = nib_mix(hi2, lo2);
      y_out = {nib_look(TD, lo3), nib_look(TC, hi3)};
   end

endmodule

// File: rtl/hfn_mds.sv
module hfn_mds
   import hfn_pkg::*;
#(
   parameter int unsigned  BYTES = 4,
   parameter logic [8:0]   POLY  = 9'h169
) (
   input  logic [BYTES*8-1:0] y_word,
   output logic [BYTES*8-1:0] z_word
);

   logic [7:0] c01 [BYTES];
   logic [7:0] c5b [BYTES];
   logic [7:0] cef [BYTES];

   // One product set per column, shared by all rows
   for (genvar c = 0; c < BYTES; c++) begin : g_col
      logic [7:0] x2, x4, x8, x16, x32, x64, x128;
      always_comb begin
         c01[c] = y_word[c*8 +: 8];
         x2     = gf_dbl(c01[c], POLY);
         x4     = gf_dbl(x2, POLY);
         x8     = gf_dbl(x4, POLY);
         x16    = gf_dbl(x8, POLY);
         x32    = gf_dbl(x16, POLY);
         x64    = gf_dbl(x32, POLY);
         x128   = gf_dbl(x64, POLY);
         c5b[c] = c01[c] ^ x2 ^ x8 ^ x16 ^ x64;
         cef[c] = c01[c] ^ x2 ^ x4 ^ x8 ^ x32 ^ x64 ^ x128;
      end
   end

   always_comb begin
      z_word[7:0]   = c01[0] ^ cef[1] ^ c5b[2] ^ c5b[3];
      z_word[15:8]  = c5b[0] ^ cef[1] ^ cef[2] ^ c01[3];
      z_word[23:16] = cef[0] ^ c5b[1] ^ c01[2] ^ cef[3];
      z_word[31:24] = cef[0] ^ c01[1] ^ cef[2] ^ c5b[3];
   end

endmodule

// File: rtl/hfn_core.sv
module hfn_core
   import hfn_pkg::*;
#(
   parameter int unsigned BYTES    = 4,
   parameter logic [8:0]  MDS_POLY = 9'h169
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [BYTES*8-1:0] word_in,
   input  logic [BYTES*8-1:0] key_inner,
   input  logic [BYTES*8-1:0] key_outer,
   output logic              valid_out,
   output logic [BYTES*8-1:0] word_out
);

   localparam int unsigned W      = BYTES * 8;
   localparam int unsigned LEVELS = 3;
   localparam int unsigned LAT    = LEVELS + 1;

   if (BYTES != 4) begin : g_bad_bytes
      $error("hfn_core: BYTES must be 4");
   end
   if (MDS_POLY[8] != 1'b1 || MDS_POLY[0] != 1'b1) begin : g_bad_poly
      $error("hfn_core: MDS_POLY must have degree 8 and constant term");
   end

   logic [W-1:0]   lvl_in  [LEVELS];
   logic [W-1:0]   lvl_out [LEVELS];
   logic [W-1:0]   lvl_q   [LEVELS];
   logic [LAT-1:0] vpipe;
   logic [W-1:0]   mix_w;

   assign lvl_in[0] = word_in;
   assign lvl_in[1] = lvl_q[0] ^ key_inner;
   assign lvl_in[2] = lvl_q[1] ^ key_outer;

   for (genvar j = 0; j < BYTES; j++) begin : g_chain
      for (genvar s = 0; s < LEVELS; s++) begin : g_lvl
         hfn_qperm #(.VARIANT(CHAIN_MAP[j*LEVELS + s])) perm_i (
            .x_in  (lvl_in[s][j*8 +: 8]),
            .y_out (lvl_out[s][j*8 +: 8])
         );
      end
   end

   hfn_mds #(.BYTES(BYTES), .POLY(MDS_POLY)) mds_i (
      .y_word (lvl_q[LEVELS-1]),
      .z_word (mix_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[LAT-2:0], valid_in};
   end

   for (genvar s = 0; s < LEVELS; s++) begin : g_stage
      logic load;
      if (s == 0) begin : g_first
         assign load = valid_in;
      end else begin : g_rest
         assign load = vpipe[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    lvl_q[s] <= '0;
         else if (load) lvl_q[s] <= lvl_out[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 word_out <= '0;
      else if (vpipe[LEVELS-1])   word_out <= mix_w;
   end

   assign valid_out = vpipe[LAT-1];

   // ---------------- assertions ----------------
   logic [2:0] rst_age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rst_age <= '0;
      else if (rst_age != 3'd4) rst_age <= rst_age + 3'd1;
   end

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!valid_out && word_out == '0));

   assert_latency_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_age == 3'd4 && $past(valid_in, 4)) |-> valid_out);

   assert_latency_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out |-> $past(valid_in, 4));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_out |-> $stable(word_out));

   assert_zero_mix_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vpipe[LEVELS-1] && lvl_q[LEVELS-1] == '0) |=> (word_out == '0));

endmodule

// File: tb/hfn_core_tb_top.sv
module hfn_core_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        valid_in;
   logic [31:0] word_in, key_inner, key_outer;
   logic        valid_out;
   logic [31:0] word_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   hfn_core dut_i (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .word_in(word_in),
      .key_inner(key_inner), .key_outer(key_outer),
      .valid_out(valid_out), .word_out(word_out)
   );

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit done   = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // ---------------- reference model ----------------
   localparam logic [3:0] QT [2][4][16] = '{
      '{ '{4'h8,4'h1,4'h7,4'hD,4'h6,4'hF,4'h3,4'h2,4'h0,4'hB,4'h5,4'h9,4'hE,4'hC,4'hA,4'h4},
         '{4'hE,4'hC,4'hB,4'h8,4'h1,4'h2,4'h3,4'h5,4'hF,4'h4,4'hA,4'h6,4'h7,4'h0,4'h9,4'hD},
         '{4'hB,4'hA,4'h5,4'hE,4'h6,4'hD,4'h9,4'h0,4'hC,4'h8,4'hF,4'h3,4'h2,4'h4,4'h7,4'h1},
         '{4'hD,4'h7,4'hF,4'h4,4'h1,4'h2,4'h6,4'hE,4'h9,4'hB,4'h3,4'h0,4'h8,4'h5,4'hC,4'hA} },
      '{ '{4'h2,4'h8,4'hB,4'hD,4'hF,4'h7,4'h6,4'hE,4'h3,4'h1,4'h9,4'h4,4'h0,4'hA,4'hC,4'h5},
         '{4'h1,4'hE,4'h2,4'hB,4'h4,4'hC,4'h3,4'h7,4'h6,4'hD,4'hA,4'h5,4'hF,4'h9,4'h0,4'h8},
         '{4'h4,4'hC,4'h7,4'h5,4'h1,4'h6,4'h9,4'hA,4'h0,4'hE,4'hD,4'h8,4'h2,4'hB,4'h3,4'hF},
         '{4'hB,4'h9,4'h5,4'h1,4'hC,4'h3,4'hD,4'hE,4'h6,4'h4,4'h7,4'hF,4'h2,4'h0,4'h8,4'hA} } };

   localparam int CH [4][3] = '{ '{0,0,1}, '{1,0,0}, '{0,1,1}, '{1,1,0} };
   localparam logic [7:0] MX [4][4] = '{ '{8'h01,8'hEF,8'h5B,8'h5B},
                                         '{8'h5B,8'hEF,8'hEF,8'h01},
                                         '{8'hEF,8'h5B,8'h01,8'hEF},
                                         '{8'hEF,8'h01,8'hEF,8'h5B} };

   function automatic logic [3:0] rr1(input logic [3:0] v);
      return {v[0], v[3:1]};
   endfunction

   function automatic logic [7:0] perm_ref(input int v, input logic [7:0] x);
      logic [3:0] a, b, na, nb;
      a = x[7:4]; b = x[3:0];
      na = QT[v][0][a ^ b];
      nb = QT[v][1][a ^ rr1(b) ^ {a[0], 3'b000}];
      a = na; b = nb;
      na = QT[v][2][a ^ b];
      nb = QT[v][3][a ^ rr1(b) ^ {a[0], 3'b000}];
      return {nb, na};
   endfunction

   function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p, aa;
      p = 8'h00; aa = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) p = p ^ aa;
         aa = aa[7] ? ((aa << 1) ^ 8'h69) : (aa << 1);
      end
      return p;
   endfunction

   function automatic logic [31:0] h_ref(input logic [31:0] w, input logic [31:0] ki,
                                         input logic [31:0] ko);
      logic [7:0] y [4];
      logic [31:0] z;
      for (int j = 0; j < 4; j++) begin
         y[j] = perm_ref(CH[j][0], w[j*8 +: 8]);
         y[j] = perm_ref(CH[j][1], y[j] ^ ki[j*8 +: 8]);
         y[j] = perm_ref(CH[j][2], y[j] ^ ko[j*8 +: 8]);
      end
      for (int r = 0; r < 4; r++) begin
         z[r*8 +: 8] = 8'h00;
         for (int c = 0; c < 4; c++) z[r*8 +: 8] = z[r*8 +: 8] ^ gmul(MX[r][c], y[c]);
      end
      return z;
   endfunction

   // ---------------- scoreboard ----------------
   typedef struct { logic [31:0] d; int due; string tag; } exp_t;
   exp_t        sb [$];
   logic [31:0] last_out = 32'h0;

   task automatic send(input logic [31:0] w, input string tag);
      exp_t e;
      @(negedge clk);
      valid_in = 1'b1;
      word_in  = w;
      e.d   = h_ref(w, key_inner, key_outer);
      e.due = cyc + 4;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         valid_in = 1'b0;
         word_in  = 32'hDEAD_BEEF;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (valid_out) begin
            checks++;
            if (sb.size() == 0) begin
               errors++;
               $display("FAIL R6 unexpected result actual=%08h expected=none", word_out);
            end else begin
               exp_t e;
               e = sb.pop_front();
               if (word_out !== e.d || cyc != e.due) begin
                  errors++;
                  $display("FAIL %s actual=%08h@%0d expected=%08h@%0d",
                           e.tag, word_out, cyc, e.d, e.due);
               end
            end
            last_out = word_out;
         end else begin
            checks++;
            if (word_out !== last_out) begin
               errors++;
               $display("FAIL R7 output moved while idle actual=%08h expected=%08h",
                        word_out, last_out);
            end
            if (sb.size() != 0 && sb[0].due < cyc) begin
               checks++;
               errors++;
               $display("FAIL R6 result missing actual=none expected=%08h@%0d",
                        sb[0].d, sb[0].due);
               void'(sb.pop_front());
            end
         end
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL R6 watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   // ---------------- stimulus ----------------
   logic [31:0] lf = 32'h1234_5678;
   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
      return t;
   endfunction

   initial begin
      rst_n = 1'b0; valid_in = 1'b0; word_in = '0;
      key_inner = '0; key_outer = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (valid_out !== 1'b0 || word_out !== 32'h0) begin
         errors++;
         $display("FAIL R1 reset actual=%b/%08h expected=0/00000000", valid_out, word_out);
      end
      rst_n = 1'b1;
      idle(2);
      checks++;
      if (valid_out !== 1'b0 || word_out !== 32'h0) begin
         errors++;
         $display("FAIL R1 after release actual=%b/%08h expected=0/00000000", valid_out, word_out);
      end

      // R2: zero and all-ones words, zero keys
      send(32'h0000_0000, "R2 zero word");
      idle(3);
      send(32'hFFFF_FFFF, "R2 ones word");
      idle(6);

      // R3: distinct key bytes, walking byte through each lane
      key_inner = 32'h0123_4567;
      key_outer = 32'h89AB_CDEF;
      for (int j = 0; j < 4; j++) begin
         send(32'h0000_00A5 << (8*j), "R3 lane walk");
         idle(1);
      end
      send(32'h0102_0304, "R3 byte order");
      send(32'h0403_0201, "R3 byte order swapped");
      idle(6);

      // R4 R5: words with high bits set drive reductions
      key_inner = 32'hF0E1_D2C3;
      key_outer = 32'h8796_A5B4;
      send(32'h8080_8080, "R4 R5 high bits");
      send(32'h7F7F_7F7F, "R4 R5 low bits");
      idle(6);

      // R6: back-to-back burst
      for (int i = 0; i < 24; i++) begin
         lf = nxt(lf);
         send(lf, "R6 burst");
      end
      idle(6);

      // R2 R4 R5 R6 R7: random words with random gaps across key sessions
      for (int s = 0; s < 4; s++) begin
         lf = nxt(lf); key_inner = lf;
         lf = nxt(lf); key_outer = lf;
         for (int i = 0; i < 60; i++) begin
            lf = nxt(lf);
            send(lf, "R2 R4 R5 random");
            if (lf[1:0] == 2'b00) idle(int'(lf[4:2]) + 1);
         end
         idle(6);
      end

      idle(8);
      // R6: every word produced exactly one result
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R6 leftover actual=%0d expected=0", sb.size());
      end
      done = 1;
      finish_run();
   end

endmodule